// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Overflow Status

This block adds or subtracts two signed two's-complement words. When the true result does not fit, the block clamps it to the most positive or most negative representable value instead of letting it wrap. Each accepted operation produces a registered result one clock later. That result comes with a flag saying whether this particular operation was clamped.

A separate sticky status bit records that at least one clamp has happened since it was last cleared. Later operations that do not clamp leave it set. Only reset, or a write of 0 through a one-bit register-style write strobe, clears it. If a clear and a new clamp arrive in the same cycle, the clamp wins.

A halfword mode reuses the same full-width clamping path. The low halfwords of the operands are moved into the upper half of the word, with zeros below, and the operation runs at full width. The upper half of the clamped word is then returned, sign-extended, so halfword results clamp at 0x7FFF and 0x8000.

Top module: `sat_addsub_unit`

## Requirements
- R1: In word mode, an operation whose true signed result exceeds 2^31-1 returns 0x7FFF_FFFF.
- R2: In word mode, an operation whose true signed result is below -2^31 returns 0x8000_0000.
- R3: With `op_sub`=1 the operation is `op_a - op_b`, including `op_b`=0x8000_0000, and it clamps under the same rules as addition (`op_sub`=0 means `op_a + op_b`).
- R4: An operation presented with `op_valid`=1 at a rising edge appears on `res_q` after that edge with `res_valid`=1. If no clamp occurs, `res_q` is the exact sum or difference.
- R5: After every edge, `op_sat` is 1 exactly when `res_valid`=1 and that operation clamped. Otherwise it is 0.
- R6: A clamp sets `sat_sticky` to 1 at the same edge that delivers the result. It stays 1 through later operations that do not clamp.
- R7: `clr_we`=1 with `clr_wdata`=0 clears `sat_sticky` at that edge. `clr_we`=1 with `clr_wdata`=1 leaves it unchanged.
- R8: If a clamping operation and a clearing write share an edge, `sat_sticky` ends at 1.
- R9: With `op_half`=1, only `op_a[15:0]` and `op_b[15:0]` take part; their upper bits are ignored. The halfword result is placed in `res_q[15:0]` with `res_q[31:16]` a sign extension, and it clamps to 0x7FFF or 0x8000 (`res_q` = 0x0000_7FFF or 0xFFFF_8000).
- R10: After reset, `res_q`=0, `res_valid`=0, `op_sat`=0 and `sat_sticky`=0.
- R11: At an edge with `op_valid`=0, `res_q` holds its value, `res_valid` and `op_sat` are 0, and `sat_sticky` changes only through a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept an operation this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract b from a |
| op_half | input | 1 | 1 = halfword mode on the low halves |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr_we | input | 1 | Write strobe for the status bit |
| clr_wdata | input | 1 | Value written; 0 clears, 1 has no effect |
| res_q | output | 32 | Registered clamped result |
| res_valid | output | 1 | res_q holds a new result |
| op_sat | output | 1 | The delivered result was clamped |
| sat_sticky | output | 1 | Latched clamp status |

## Verification
The bench targets the operand pairs at the clamp limits:
- the most negative value subtracted from zero and from -1;
- sums that land exactly on the limits;
- the halfword limits, with junk in the upper halves.

A design that detected overflow on the raw inverted operand or its carry would flag `0 - 0x8000_0000` wrongly, or return 0x8000_0000 where 0x7FFF_FFFF is due. A halfword path that kept the upper operand bits, or skipped the sign extension, would show wrong upper bits in `res_q`. The bench also collides a clear with a clamp in the same cycle and writes 1 to the status bit. A reversed priority, or a write that loads the bit instead of only clearing it, then shows up as a wrong `sat_sticky`.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int SAT_W = 32;

  typedef enum logic {
    OPK_ADD = 1'b0,
    OPK_SUB = 1'b1
  } op_kind_e;

  typedef enum logic {
    MODE_WORD = 1'b0,
    MODE_HALF = 1'b1
  } width_mode_e;
endpackage

// File: rtl/sat_align.sv
module sat_align #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0] x_i,
  input  logic         half_i,
  output logic [W-1:0] y_o
);
  localparam int HW = W / 2;

  // Halfword mode: the low half moves to the top, with zeros below.
  function automatic logic [W-1:0] to_upper(input logic [W-1:0] v);
    return {v[HW-1:0], {(W-HW){1'b0}}};
  endfunction

  always_comb begin
    y_o = (half_i == sat_pkg::MODE_HALF) ? to_upper(x_i) : x_i;
  end
endmodule

// File: rtl/sat_core.sv
module sat_core #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] raw_o,
  output logic         ovf_pos_o,
  output logic         ovf_neg_o,
  output logic [W-1:0] clip_o
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] eff_b(input logic [W-1:0] b, input logic sub);
    return sub ? ~b : b;
  endfunction

  function automatic logic [W-1:0] wrap_sum(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic sub);
    return a + eff_b(b, sub) + {{(W-1){1'b0}}, sub};
  endfunction

  // Overflow: the operands, once b is adjusted, share a sign and the wrapped sum has the other sign.
  function automatic logic overflowed(input logic sa, input logic sbe, input logic sr);
    return (sa == sbe) && (sr != sa);
  endfunction

  logic [W-1:0] b_eff;
  logic         ovf;

  always_comb begin
    b_eff     = eff_b(b_i, sub_i);
    raw_o     = wrap_sum(a_i, b_i, sub_i);
    ovf       = overflowed(a_i[W-1], b_eff[W-1], raw_o[W-1]);
    ovf_pos_o = ovf && !a_i[W-1];
    ovf_neg_o = ovf && a_i[W-1];
    if (ovf_pos_o)      clip_o = POS_LIM;
    else if (ovf_neg_o) clip_o = NEG_LIM;
    else                clip_o = raw_o;
  end
endmodule

// File: rtl/sat_pick.sv
module sat_pick #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0] y_i,
  input  logic         half_i,
  output logic [W-1:0] r_o
);
  localparam int HW = W / 2;

  // Halfword mode: return the upper half, sign-extended.
  function automatic logic [W-1:0] from_upper(input logic [W-1:0] v);
    return {{HW{v[W-1]}}, v[W-1:W-HW]};
  endfunction

  always_comb begin
    r_o = (half_i == sat_pkg::MODE_HALF) ? from_upper(y_i) : y_i;
  end
endmodule

// File: rtl/sat_sticky_bit.sv
module sat_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A set takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_sub,
  input  logic         op_half,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr_we,
  input  logic         clr_wdata,
  output logic [W-1:0] res_q,
  output logic         res_valid,
  output logic         op_sat,
  output logic         sat_sticky
);
  localparam int NOPS = 2;

  logic [W-1:0] opnd_in  [NOPS];
  logic [W-1:0] opnd_aln [NOPS];

  assign opnd_in[0] = op_a;
  assign opnd_in[1] = op_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_align
    sat_align #(.W(W)) u_align (
      .x_i    (opnd_in[gi]),
      .half_i (op_half),
      .y_o    (opnd_aln[gi])
    );
  end

  logic [W-1:0] raw_sum;
  logic         ovf_pos;
  logic         ovf_neg;
  logic [W-1:0] clip_word;
  logic [W-1:0] pick_word;

  sat_core #(.W(W)) u_core (
    .a_i       (opnd_aln[0]),
    .b_i       (opnd_aln[1]),
    .sub_i     (op_sub),
    .raw_o     (raw_sum),
    .ovf_pos_o (ovf_pos),
    .ovf_neg_o (ovf_neg),
    .clip_o    (clip_word)
  );

  sat_pick #(.W(W)) u_pick (
    .y_i    (clip_word),
    .half_i (op_half),
    .r_o    (pick_word)
  );

  // Named events, brought out for the checker.
  logic set_evt;
  logic clr_evt;
  assign set_evt = op_valid && (ovf_pos || ovf_neg);
  assign clr_evt = clr_we && !clr_wdata;

  sat_sticky_bit u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_evt),
    .clr_i (clr_evt),
    .q_o   (sat_sticky)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
      op_sat    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      op_sat    <= set_evt;
      if (op_valid) res_q <= pick_word;
    end
  end
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int W = sat_pkg::SAT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         set_evt,
  input logic         clr_evt,
  input logic [W-1:0] res_q,
  input logic         res_valid,
  input logic         op_sat,
  input logic         sat_sticky
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] WPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] HPOS = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [W-1:0] HNEG = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};

  p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> sat_sticky);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !clr_evt) |=> sat_sticky);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !sat_sticky);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && set_evt) |=> sat_sticky);

  p_flag_in_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_sat |-> (sat_sticky && res_valid));

  p_rise_needs_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> op_sat);

  p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !op_sat && $stable(res_q)));

  p_clip_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_sat |-> (res_q == WPOS || res_q == WNEG || res_q == HPOS || res_q == HNEG));
endmodule

bind sat_addsub_unit sat_addsub_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .set_evt    (set_evt),
  .clr_evt    (clr_evt),
  .res_q      (res_q),
  .res_valid  (res_valid),
  .op_sat     (op_sat),
  .sat_sticky (sat_sticky)
);

// File: tb/sat_addsub_unit_tb.sv
module sat_addsub_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0, op_sub = 1'b0, op_half = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         clr_we = 1'b0, clr_wdata = 1'b0;
  logic [W-1:0] res_q;
  logic         res_valid, op_sat, sat_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  logic exp_sticky = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_addsub_unit #(.W(W)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bench model: exact arithmetic in 64 bits, then clamp to the limits of the chosen width.
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic sub, input logic half);
    longint sa, sb, r, hi, lo;
    logic [31:0] o;
    logic s;
    if (half) begin
      sa = longint'($signed(a[15:0])); sb = longint'($signed(b[15:0]));
      hi = 32767; lo = -32768;
    end else begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      hi = 64'sd2147483647; lo = -64'sd2147483648;
    end
    r = sub ? sa - sb : sa + sb;
    s = (r > hi) || (r < lo);
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    o = r[31:0];
    return {s, o};
  endfunction

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic half, input logic do_clr);
    logic [32:0] e;
    e = model(a, b, sub, half);
    @(negedge clk);
    op_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; op_half = half;
    clr_we = do_clr; clr_wdata = 1'b0;
    if (e[32]) exp_sticky = 1'b1;
    else if (do_clr) exp_sticky = 1'b0;
    @(posedge clk); #1;
    check({req, " result"}, {32'd0, res_q}, {32'd0, e[31:0]});
    check("R5 op_sat", {63'd0, op_sat}, {63'd0, e[32]});
    check("R4 res_valid", {63'd0, res_valid}, 64'd1);
    check("R6 sticky", {63'd0, sat_sticky}, {63'd0, exp_sticky});
    @(negedge clk);
    op_valid = 1'b0; clr_we = 1'b0;
  endtask

  task automatic write_status(input string req, input logic v);
    @(negedge clk);
    clr_we = 1'b1; clr_wdata = v;
    if (!v) exp_sticky = 1'b0;
    @(posedge clk); #1;
    check(req, {63'd0, sat_sticky}, {63'd0, exp_sticky});
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = 1'b0;
  endtask

  function automatic logic [31:0] pick_operand(input int unsigned sel);
    case (sel % 6)
      0: return 32'h7FFF_FFFF - ($urandom % 8);
      1: return 32'h8000_0000 + ($urandom % 8);
      2: return {16'($urandom), 16'h7FF0 + 16'($urandom % 16)};
      3: return {16'($urandom), 16'h8000 + 16'($urandom % 16)};
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240517));
    #(CLK_PERIOD*2 + 3);
    // R10 reset state
    check("R10 res_q", {32'd0, res_q}, 64'd0);
    check("R10 res_valid", {63'd0, res_valid}, 64'd0);
    check("R10 op_sat", {63'd0, op_sat}, 64'd0);
    check("R10 sticky", {63'd0, sat_sticky}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    run_op("R4 plain add", 32'd1234, 32'd4321, 1'b0, 1'b0, 1'b0);
    run_op("R4 negative add", 32'hFFFF_FF00, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
    run_op("R4 exact upper limit", 32'h7FFF_FFFE, 32'd1, 1'b0, 1'b0, 1'b0);
    run_op("R1 positive clamp", 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);
    run_op("R6 hold after plain op", 32'd5, 32'd6, 1'b0, 1'b0, 1'b0);
    write_status("R7 write one keeps sticky", 1'b1);
    write_status("R7 write zero clears sticky", 1'b0);
    run_op("R2 negative clamp", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    write_status("R7 clear", 1'b0);
    run_op("R3 zero minus most negative", 32'd0, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    run_op("R3 minus one minus most negative", 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    run_op("R3 negative sub clamp", 32'h8000_0000, 32'd1, 1'b1, 1'b0, 1'b0);
    run_op("R8 clamp with clear", 32'h7000_0000, 32'h7000_0000, 1'b0, 1'b0, 1'b1);
    run_op("R7 clear with plain op", 32'd3, 32'd4, 1'b1, 1'b0, 1'b1);
    run_op("R9 half plain with junk", 32'hABCD_0100, 32'h1234_FF00, 1'b0, 1'b1, 1'b0);
    run_op("R9 half positive clamp", 32'hFFFF_7FFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0);
    run_op("R9 half negative clamp", 32'h5555_8000, 32'hAAAA_0001, 1'b1, 1'b1, 1'b0);
    run_op("R9 half zero minus most negative", 32'h0000_0000, 32'h7777_8000, 1'b1, 1'b1, 1'b1);

    // R11 idle cycle: res_q holds, no valid, no flag
    held = res_q;
    @(negedge clk); op_a = 32'h7FFF_FFFF; op_b = 32'h7FFF_FFFF;
    @(posedge clk); #1;
    check("R11 res_q hold", {32'd0, res_q}, {32'd0, held});
    check("R11 res_valid low", {63'd0, res_valid}, 64'd0);
    check("R11 op_sat low", {63'd0, op_sat}, 64'd0);
    check("R11 sticky unchanged", {63'd0, sat_sticky}, {63'd0, exp_sticky});

    for (int i = 0; i < 400; i++) begin
      run_op("R1 R2 R3 R9 random", pick_operand($urandom), pick_operand($urandom),
             1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 7 == 0));
    end

    done = 1'b1;
    finish_run();
  end
endmodule